// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one programmable performance counter for a processor core. Every clock it receives a small binary number: how many times the watched event occurred in that cycle. It also receives the privilege level the core is running at. A configuration word decides how that number is turned into an increment. The increment can be the raw count. It can be one step per cycle that passes a threshold test, which may be inverted. It can be one step per new occurrence of a condition that lasts several cycles. The configuration also chooses which privilege levels may count at all.

The result accumulates in a 48-bit counter. Software can load the counter and read it at any time. When the counter wraps past its largest value, a sticky overflow flag is set. The flag drives an interrupt line when interrupts are enabled. Software clears the flag with a one-cycle clear strobe.

The configuration word has these bits: bit 0 global enable, bit 1 kernel enable, bit 2 user enable, bit 3 edge mode, bit 4 invert, bit 5 interrupt enable, and bits 6 and up the threshold. A configuration write takes effect from the following cycle.

Top module: `evtc_counter`

## Requirements
- R1: After reset the counter reads 0, the overflow flag and the interrupt are low, and the configuration is all zero, so counting is off.
- R2: While the global enable (config bit 0) is 0, event input has no effect: the counter keeps its value and the edge history is held at false.
- R3: With the threshold field (config bits 6 and up) equal to 0 and edge mode off, each enabled cycle adds the raw event count to the counter; the invert bit (config bit 4) changes nothing.
- R4: With a nonzero threshold, a cycle adds one when its event count is greater than or equal to the threshold, and adds nothing otherwise.
- R5: With a nonzero threshold and the invert bit set, a cycle adds one when its event count is below the threshold, and adds nothing otherwise.
- R6: With edge mode (config bit 3) set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. The qualified condition is the threshold test, or a nonzero event count when the threshold is 0, gated by privilege.
- R7: Disabling the counter clears the edge history. A condition that is already true in the first cycle after re-enabling therefore counts once as a new occurrence.
- R8: Kernel enable (config bit 1) allows counting at privilege level 0. User enable (config bit 2) allows counting at privilege levels 1, 2 and 3. A level whose bit is off adds nothing.
- R9: When both privilege enable bits are 0, every privilege level counts.
- R10: A counter write loads the written value, and it wins over any increment in the same cycle.
- R11: A carry out of the 48-bit counter sets the sticky overflow flag. The clear strobe drops the flag, except in a cycle with a new wrap, where the flag stays set. A counter write never sets the flag.
- R12: The interrupt output is high exactly when the overflow flag is set and the interrupt enable (config bit 5) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | EVT_W | Number of event occurrences in this cycle |
| priv_i | input | 2 | Current privilege level, 0 is kernel |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6+THR_W | Configuration word (layout in the description above) |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | Value loaded into the counter |
| ovf_clr_i | input | 1 | Clear strobe for the overflow flag |
| cnt_o | output | CNT_W | Current counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach from the ports is the 48-bit wrap: no practical run of events carries the counter that far. The stimulus first loads the counter to within a few counts of all-ones through the write port, then drives a multi-count cycle across the boundary. A second case makes a wrap collide with the clear strobe in the same cycle. The other awkward case is the edge history across a disable: the stimulus holds a condition true, turns the enable off and back on through configuration writes, and expects exactly one extra count.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

   // Bit positions inside the configuration word.
   localparam int unsigned CFG_EN_BIT   = 0;
   localparam int unsigned CFG_KERN_BIT = 1;
   localparam int unsigned CFG_USER_BIT = 2;
   localparam int unsigned CFG_EDGE_BIT = 3;
   localparam int unsigned CFG_INV_BIT  = 4;
   localparam int unsigned CFG_IRQ_BIT  = 5;
   localparam int unsigned CFG_THR_LSB  = 6;

   localparam logic [1:0] PRIV_KERNEL = 2'd0;

   // Flag bits in the same order as the low six bits of the word.
   typedef struct packed {
      logic irq_en;
      logic inv;
      logic edge_on;
      logic user_en;
      logic kern_en;
      logic enable;
   } evtc_flags_t;

endpackage

// File: rtl/evtc_cfg_reg.sv
module evtc_cfg_reg
   import evtc_pkg::*;
#(
   parameter int unsigned THR_W = 4,
   localparam int unsigned CFG_W = CFG_THR_LSB + THR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CFG_W-1:0]  wdata_i,
   output evtc_flags_t       flags_o,
   output logic [THR_W-1:0]  thr_o
);

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_i) begin
         cfg_q <= wdata_i;
      end
   end

   assign flags_o = evtc_flags_t'(cfg_q[CFG_THR_LSB-1:0]);
   assign thr_o   = cfg_q[CFG_THR_LSB +: THR_W];

endmodule

// File: rtl/evtc_qualify.sv
module evtc_qualify
   import evtc_pkg::*;
#(
   parameter int unsigned EVT_W    = 4,
   parameter int unsigned THR_W    = 4,
   parameter bit          HAS_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  evtc_flags_t       flags_i,
   input  logic [THR_W-1:0]  thr_i,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic [1:0]        priv_i,
   output logic [EVT_W-1:0]  inc_o
);

   localparam int unsigned CMP_W = (EVT_W > THR_W) ? EVT_W : THR_W;

   logic [CMP_W-1:0] evt_x;
   logic [CMP_W-1:0] thr_x;
   logic             thr_zero;
   logic             at_or_above;
   logic             no_priv_sel;
   logic             priv_ok;
   logic             cond_raw;
   logic             cond_g;
   logic             step;

   assign evt_x       = CMP_W'(evt_i);
   assign thr_x       = CMP_W'(thr_i);
   assign thr_zero    = (thr_i == '0);
   assign at_or_above = (evt_x >= thr_x);

   // Privilege gate: with neither level selected, every level is allowed.
   assign no_priv_sel = !flags_i.kern_en && !flags_i.user_en;
   assign priv_ok     = (priv_i == PRIV_KERNEL) ? (flags_i.kern_en || no_priv_sel)
                                                : (flags_i.user_en || no_priv_sel);

   always_comb begin
      if (thr_zero) begin
         cond_raw = (evt_i != '0);
      end else if (flags_i.inv) begin
         cond_raw = !at_or_above;
      end else begin
         cond_raw = at_or_above;
      end
   end

   assign cond_g = cond_raw && priv_ok;

   generate
      if (HAS_EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
            end else begin
               prev_q <= flags_i.enable ? cond_g : 1'b0;
            end
         end
         assign step = flags_i.edge_on ? (cond_g && !prev_q) : cond_g;
      end else begin : g_level
         assign step = cond_g;
      end
   endgenerate

   always_comb begin
      if (HAS_EDGE && flags_i.edge_on) begin
         inc_o = EVT_W'(step);
      end else if (thr_zero) begin
         inc_o = priv_ok ? evt_i : '0;
      end else begin
         inc_o = EVT_W'(step);
      end
   end

endmodule

// File: rtl/evtc_accum.sv
module evtc_accum #(
   parameter int unsigned CNT_W = 48,
   parameter int unsigned EVT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [EVT_W-1:0]  inc_i,
   input  logic              wr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   input  logic              ovf_clr_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              ovf_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic [CNT_W:0]   sum;
   logic             wrap;

   assign sum  = {1'b0, cnt_q} + {{(CNT_W + 1 - EVT_W){1'b0}}, inc_i};
   assign wrap = en_i && !wr_i && sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_i) begin
         cnt_q <= wdata_i;
      end else if (en_i) begin
         cnt_q <= sum[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (wrap) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr_i) begin
         ovf_q <= 1'b0;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

endmodule

// File: rtl/evtc_counter.sv
module evtc_counter
   import evtc_pkg::*;
#(
   parameter int unsigned EVT_W    = 4,
   parameter int unsigned THR_W    = EVT_W,
   parameter int unsigned CNT_W    = 48,
   parameter bit          HAS_EDGE = 1'b1,
   localparam int unsigned CFG_W   = CFG_THR_LSB + THR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic [1:0]        priv_i,
   input  logic              cfg_wr_i,
   input  logic [CFG_W-1:0]  cfg_wdata_i,
   input  logic              cnt_wr_i,
   input  logic [CNT_W-1:0]  cnt_wdata_i,
   input  logic              ovf_clr_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              ovf_o,
   output logic              irq_o
);

   generate
      if (EVT_W < 1) begin : g_bad_evt
         $error("evtc_counter: EVT_W must be at least 1");
      end
      if (THR_W < 1) begin : g_bad_thr
         $error("evtc_counter: THR_W must be at least 1");
      end
      if (CNT_W <= EVT_W) begin : g_bad_cnt
         $error("evtc_counter: CNT_W must exceed EVT_W");
      end
   endgenerate

   evtc_flags_t      flags;
   logic [THR_W-1:0] thr;
   logic [EVT_W-1:0] inc;

   evtc_cfg_reg #(
      .THR_W   (THR_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr_i),
      .wdata_i (cfg_wdata_i),
      .flags_o (flags),
      .thr_o   (thr)
   );

   evtc_qualify #(
      .EVT_W    (EVT_W),
      .THR_W    (THR_W),
      .HAS_EDGE (HAS_EDGE)
   ) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flags),
      .thr_i   (thr),
      .evt_i   (evt_i),
      .priv_i  (priv_i),
      .inc_o   (inc)
   );

   evtc_accum #(
      .CNT_W     (CNT_W),
      .EVT_W     (EVT_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (flags.enable),
      .inc_i     (inc),
      .wr_i      (cnt_wr_i),
      .wdata_i   (cnt_wdata_i),
      .ovf_clr_i (ovf_clr_i),
      .cnt_o     (cnt_o),
      .ovf_o     (ovf_o)
   );

   assign irq_o = ovf_o && flags.irq_en;

endmodule

// File: rtl/evtc_checker.sv
module evtc_checker
   import evtc_pkg::*;
#(
   parameter int unsigned EVT_W = 4,
   parameter int unsigned THR_W = 4,
   parameter int unsigned CNT_W = 48,
   localparam int unsigned CFG_W = CFG_THR_LSB + THR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [EVT_W-1:0]  evt_i,
   input logic              cfg_wr_i,
   input logic [CFG_W-1:0]  cfg_wdata_i,
   input logic              cnt_wr_i,
   input logic [CNT_W-1:0]  cnt_wdata_i,
   input logic              ovf_clr_i,
   input logic [CNT_W-1:0]  cnt_o,
   input logic              ovf_o,
   input logic              irq_o
);

   // Shadow of the configuration, rebuilt from the write port alone.
   logic [CFG_W-1:0] sh_cfg;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_cfg <= '0;
      end else if (cfg_wr_i) begin
         sh_cfg <= cfg_wdata_i;
      end
   end

   logic sh_en;
   logic sh_ie;
   logic sh_thr_nz;
   assign sh_en     = sh_cfg[CFG_EN_BIT];
   assign sh_ie     = sh_cfg[CFG_IRQ_BIT];
   assign sh_thr_nz = (sh_cfg[CFG_THR_LSB +: THR_W] != '0);

   p_reset_state_r1: assert property (@(posedge clk) !rst_n |=> (cnt_o == '0) && !ovf_o);

   p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sh_en && !cnt_wr_i && (evt_i != '0)) |=> $stable(cnt_o));

   p_thr_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_en && sh_thr_nz && !cnt_wr_i) |=> ((cnt_o - $past(cnt_o)) <= CNT_W'(1)));

   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)));

   p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ovf_clr_i) |=> ovf_o);

   p_ovf_on_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> (cnt_o < $past(cnt_o)));

   p_irq_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (ovf_o && sh_ie));

endmodule

bind evtc_counter evtc_checker #(
   .EVT_W (EVT_W),
   .THR_W (THR_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_i       (evt_i),
   .cfg_wr_i    (cfg_wr_i),
   .cfg_wdata_i (cfg_wdata_i),
   .cnt_wr_i    (cnt_wr_i),
   .cnt_wdata_i (cnt_wdata_i),
   .ovf_clr_i   (ovf_clr_i),
   .cnt_o       (cnt_o),
   .ovf_o       (ovf_o),
   .irq_o       (irq_o)
);

// File: tb/evtc_counter_test.sv
module evtc_counter_test;

   localparam int EVT_W = 4;
   localparam int THR_W = 4;
   localparam int CNT_W = 48;
   localparam int CFG_W = 6 + THR_W;

   typedef struct {
      logic [CNT_W-1:0] cnt;
      logic             ovf;
      logic             irq;
      string            tag;
   } exp_t;

   exp_t sb[$];
   int   n_vec = 0;
   int   n_bad = 0;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n;
   logic [EVT_W-1:0] evt_i;
   logic [1:0]       priv_i;
   logic             cfg_wr_i;
   logic [CFG_W-1:0] cfg_wdata_i;
   logic             cnt_wr_i;
   logic [CNT_W-1:0] cnt_wdata_i;
   logic             ovf_clr_i;
   logic [CNT_W-1:0] cnt_o;
   logic             ovf_o;
   logic             irq_o;

   evtc_counter #(.EVT_W(EVT_W), .THR_W(THR_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .priv_i(priv_i),
      .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
      .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
      .ovf_clr_i(ovf_clr_i), .cnt_o(cnt_o), .ovf_o(ovf_o), .irq_o(irq_o)
   );

   // Reference state kept from the requirements.
   logic [CNT_W-1:0] m_cnt  = '0;
   logic             m_ovf  = 1'b0;
   logic             m_prev = 1'b0;
   logic [CFG_W-1:0] m_cfg  = '0;

   function automatic logic [CFG_W-1:0] mkcfg(bit en, bit k, bit u, bit ed, bit inv, bit ie, int thr);
      return {THR_W'(thr), ie, inv, ed, u, k, en};
   endfunction

   task automatic drive(input bit cw, input logic [CFG_W-1:0] cv, input bit nw,
                        input logic [CNT_W-1:0] nv, input bit clr, input int evt,
                        input int pr, input string tag);
      int          thr;
      bit          en, k, u, ed, inv, none, pok, cond, cg, rise, wrap;
      int          inc;
      logic [CNT_W:0] sum;
      exp_t        e;
      @(negedge clk);
      cfg_wr_i    = cw;
      cfg_wdata_i = cv;
      cnt_wr_i    = nw;
      cnt_wdata_i = nv;
      ovf_clr_i   = clr;
      evt_i       = EVT_W'(evt);
      priv_i      = 2'(pr);
      thr  = int'(m_cfg[6 +: THR_W]);
      en   = m_cfg[0]; k = m_cfg[1]; u = m_cfg[2];
      ed   = m_cfg[3]; inv = m_cfg[4];
      none = !k && !u;
      pok  = (pr == 0) ? (k || none) : (u || none);
      if (thr == 0) cond = (evt != 0);
      else          cond = inv ? (evt < thr) : (evt >= thr);
      cg   = cond && pok;
      rise = cg && !m_prev;
      if (ed)            inc = int'(rise);
      else if (thr == 0) inc = pok ? evt : 0;
      else               inc = int'(cg);
      m_prev = en ? cg : 1'b0;
      wrap = 1'b0;
      if (nw) m_cnt = nv;
      else if (en) begin
         sum   = {1'b0, m_cnt} + (CNT_W+1)'(inc);
         m_cnt = sum[CNT_W-1:0];
         wrap  = sum[CNT_W];
      end
      if (wrap)     m_ovf = 1'b1;
      else if (clr) m_ovf = 1'b0;
      if (cw) m_cfg = cv;
      e.cnt = m_cnt;
      e.ovf = m_ovf;
      e.irq = m_ovf && m_cfg[5];
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic ev(input int evt, input int pr, input string tag);
      drive(0, '0, 0, '0, 0, evt, pr, tag);
   endtask

   task automatic setcfg(input logic [CFG_W-1:0] cv, input string tag);
      drive(1, cv, 0, '0, 0, 0, 0, tag);
   endtask

   // Monitor: compares one expected item per cycle, after the edge settles.
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            n_vec++;
            if (cnt_o !== e.cnt || ovf_o !== e.ovf || irq_o !== e.irq) begin
               n_bad++;
               $display("FAIL %s: cnt=%0d ovf=%0b irq=%0b expected cnt=%0d ovf=%0b irq=%0b",
                        e.tag, cnt_o, ovf_o, irq_o, e.cnt, e.ovf, e.irq);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; evt_i = '0; priv_i = '0; cfg_wr_i = 1'b0; cfg_wdata_i = '0;
      cnt_wr_i = 1'b0; cnt_wdata_i = '0; ovf_clr_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if (cnt_o !== '0 || ovf_o !== 1'b0 || irq_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: cnt=%0d ovf=%0b irq=%0b expected 0 0 0", cnt_o, ovf_o, irq_o);
      end

      // R2: disabled counter ignores events
      ev(5, 0, "R2 disabled");
      ev(15, 3, "R2 disabled");

      // R3: raw accumulation with zero threshold, invert has no effect
      setcfg(mkcfg(1, 1, 1, 0, 0, 0, 0), "R3 cfg");
      ev(3, 0, "R3 raw");
      ev(0, 1, "R3 raw");
      ev(7, 2, "R3 raw");
      ev(15, 3, "R3 raw");
      setcfg(mkcfg(1, 1, 1, 0, 1, 0, 0), "R3 cfg inv");
      ev(4, 0, "R3 inv ignored");
      ev(0, 0, "R3 inv ignored");

      // R4: threshold compare
      setcfg(mkcfg(1, 1, 1, 0, 0, 0, 4), "R4 cfg");
      ev(3, 0, "R4 below");
      ev(4, 0, "R4 equal");
      ev(9, 1, "R4 above");
      ev(0, 2, "R4 zero");

      // R5: inverted threshold compare
      setcfg(mkcfg(1, 1, 1, 0, 1, 0, 4), "R5 cfg");
      ev(3, 0, "R5 below");
      ev(4, 0, "R5 equal");
      ev(0, 3, "R5 zero");
      ev(15, 3, "R5 above");

      // R6: edge counting with threshold 1
      setcfg(mkcfg(1, 1, 1, 1, 0, 0, 1), "R6 cfg");
      ev(2, 0, "R6 rise");
      ev(2, 0, "R6 hold");
      ev(3, 0, "R6 hold");
      ev(0, 0, "R6 fall");
      ev(1, 0, "R6 rise2");
      ev(1, 0, "R6 hold2");

      // R7: disable clears history; held condition counts again on re-enable
      drive(1, mkcfg(0, 1, 1, 1, 0, 0, 1), 0, '0, 0, 1, 0, "R7 disable");
      ev(1, 0, "R7 disabled");
      drive(1, mkcfg(1, 1, 1, 1, 0, 0, 1), 0, '0, 0, 1, 0, "R7 enable");
      ev(1, 0, "R7 first enabled");
      ev(1, 0, "R7 held");

      // R8: privilege gating
      setcfg(mkcfg(1, 1, 0, 0, 0, 0, 0), "R8 cfg kernel");
      ev(5, 0, "R8 kernel counts");
      ev(5, 2, "R8 user blocked");
      setcfg(mkcfg(1, 0, 1, 0, 0, 0, 0), "R8 cfg user");
      ev(5, 0, "R8 kernel blocked");
      ev(6, 3, "R8 user counts");
      ev(2, 1, "R8 user counts");

      // R9: no privilege bit means all levels count
      setcfg(mkcfg(1, 0, 0, 0, 0, 0, 0), "R9 cfg");
      ev(2, 0, "R9 level0");
      ev(3, 1, "R9 level1");

      // R10: write wins over increment
      drive(0, '0, 1, 48'd100, 0, 9, 0, "R10 write with events");
      ev(1, 0, "R10 after write");

      // R11/R12: overflow, sticky flag, interrupt enable, clear
      drive(0, '0, 1, 48'hFFFF_FFFF_FFFE, 0, 0, 0, "R11 preload");
      ev(3, 0, "R11 wrap");
      ev(2, 0, "R11 sticky");
      setcfg(mkcfg(1, 0, 0, 0, 0, 1, 0), "R12 irq enable");
      drive(0, '0, 0, '0, 1, 0, 0, "R11 clear");
      drive(0, '0, 1, 48'hFFFF_FFFF_FFFF, 0, 0, 0, "R11 preload2");
      drive(0, '0, 0, '0, 1, 1, 0, "R11 wrap beats clear");
      drive(0, '0, 1, 48'd0, 0, 4, 0, "R11 write keeps flag");
      setcfg(mkcfg(1, 0, 0, 0, 0, 0, 0), "R12 irq disable");
      drive(0, '0, 0, '0, 1, 0, 0, "R11 clear2");
      ev(0, 0, "R1 idle");

      repeat (4) @(posedge clk);
      while (sb.size() > 0) @(posedge clk);
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule